// File: doc/BRIEF.md
# Snoopable Writeback Line Buffer

This block holds outgoing 64-byte lines on their way from a cache to the system interconnect. A line can be an evicted dirty line (writeback), a block store, or an outgoing interrupt vector. Each line is tagged with its kind. Lines leave in arrival order through a valid/ready dequeue port.

While a writeback or block-store line waits in the buffer, it stays inside the coherence domain. A copyback snoop whose line address matches it is answered directly from the buffer as four 16-byte beats. The matching line stays queued and still drains normally. Interrupt-vector entries are never matched by snoops.

A configuration input can restrict a two-entry buffer to a single entry. The restriction (or its removal) only takes effect once the buffer has emptied.

Top module: `wb_line_buf`

## Requirements
- R1: Each entry stores a full 512-bit line, its line address and a 2-bit kind. A drained entry presents exactly the line and kind that were enqueued with it.
- R2: Entries drain in first-in, first-out order. `deq_valid` is high whenever the buffer holds an entry. An entry leaves on a clock edge where `deq_valid` and `deq_ready` are both high. While `deq_ready` is low, the head entry on the dequeue port does not change.
- R3: `enq_ready` is high and `full` is low exactly when the entry count is below the active limit. An enqueue offered while full is refused and leaves the contents unchanged. An enqueue and a dequeue on a full buffer in the same cycle still refuse the enqueue.
- R4: With `cfg_single`=1 the active limit is one entry; with `cfg_single`=0 it is `MAX_DEPTH` (2). The limit register loads `cfg_single` on every clock edge at which the buffer held no entry, and at no other edge. After reset the limit is `MAX_DEPTH` until the first such load.
- R5: A snoop request is accepted on an edge where `snp_busy` is low; a request made while `snp_busy` is high is ignored. For an accepted request, `snp_done` is high in the next cycle, with `snp_hit` giving the result. `snp_hit` is low whenever `snp_done` is low.
- R6: A snoop hits only an entry of kind 0 (writeback) or 1 (block store) whose line address equals `snp_addr`. Kinds 2 (interrupt vector) and 3 never hit.
- R7: On a hit, beats 0 to 3 appear on consecutive cycles, starting in the `snp_done` cycle, with `snp_beat_valid` high. Beat i is line bits [128i+127:128i], and `snp_beat_idx` equals i. `snp_busy` is high for those four cycles. The hit entry stays queued.
- R8: When several entries match a snoop, the most recently enqueued one supplies the data.
- R9: A snoop sees the buffer contents as they were before the same edge's enqueue or dequeue. An entry dequeued on that edge can still hit; an entry enqueued on that edge cannot.
- R10: After reset the buffer is empty: `empty`=1, `full`=0, `deq_valid`=0, `enq_ready`=1, and `snp_busy`, `snp_done` and `snp_beat_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_single | input | 1 | Requests a one-entry limit (applied when empty) |
| enq_valid | input | 1 | Enqueue offer |
| enq_kind | input | 2 | 0 writeback, 1 block store, 2 interrupt vector |
| enq_addr | input | AW (26) | Line address of the offered entry |
| enq_line | input | LINE_W (512) | Line data |
| enq_ready | output | 1 | Enqueue is accepted this cycle |
| deq_ready | input | 1 | Interconnect takes the head entry |
| deq_valid | output | 1 | Head entry present |
| deq_kind | output | 2 | Kind of the head entry |
| deq_addr | output | AW (26) | Line address of the head entry |
| deq_line | output | LINE_W (512) | Line data of the head entry |
| snp_req | input | 1 | Copyback snoop request |
| snp_addr | input | AW (26) | Snooped line address |
| snp_busy | output | 1 | Snoop beats in progress; requests ignored |
| snp_done | output | 1 | Snoop result cycle |
| snp_hit | output | 1 | Snoop matched a buffered line |
| snp_beat_valid | output | 1 | Snoop data beat present |
| snp_beat_idx | output | 2 | Index of the current beat |
| snp_beat_data | output | BEAT_W (128) | Snoop data beat |
| full | output | 1 | Count equals the active limit |
| empty | output | 1 | No entries held |

## Verification
A wrong head pointer or count shows up at once on the dequeue port: the wrong line appears, or `deq_valid`/`full` is wrong in the very next cycle. A stale limit register only shows up when an enqueue lands on a one-entry or two-entry boundary, so the bench toggles `cfg_single` both while entries are held and while the buffer is empty. A bad match or priority in the snoop path appears one cycle after the request as a wrong `snp_hit` or a wrong beat 0. A bad beat counter corrupts beats 1 to 3 or the `snp_busy` window within four cycles. The reference model compares every output on every clock, so each of these faults is caught in the cycle it first appears.

// File: rtl/wbb_pkg.sv
package wbb_pkg;

    typedef enum logic [1:0] {
        KIND_WB   = 2'd0,
        KIND_BST  = 2'd1,
        KIND_INTR = 2'd2,
        KIND_RSVD = 2'd3
    } kind_e;

    function automatic logic kind_snoopable(input logic [1:0] k);
        return (k == KIND_WB) || (k == KIND_BST);
    endfunction

endpackage

// File: rtl/wbb_queue.sv
module wbb_queue #(
    parameter int AW    = 26,
    parameter int LW    = 512,
    parameter int DEPTH = 2,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_single,
    input  logic                       enq_valid,
    input  logic [1:0]                 enq_kind,
    input  logic [AW-1:0]              enq_addr,
    input  logic [LW-1:0]              enq_line,
    output logic                       enq_ready,
    input  logic                       deq_ready,
    output logic                       deq_valid,
    output logic [1:0]                 deq_kind,
    output logic [AW-1:0]              deq_addr,
    output logic [LW-1:0]              deq_line,
    output logic                       full,
    output logic                       empty,
    output logic [DEPTH-1:0][1:0]      slot_kind,
    output logic [DEPTH-1:0][AW-1:0]   slot_addr,
    output logic [DEPTH-1:0][LW-1:0]   slot_line,
    output logic [PW-1:0]              head,
    output logic [CW-1:0]              count
);

    typedef struct packed {
        logic [PW-1:0]            head;
        logic [CW-1:0]            count;
        logic                     lim_one;
        logic [DEPTH-1:0][1:0]    kind;
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][LW-1:0] line;
    } qstate_t;

    qstate_t q_q, q_d;
    logic [CW-1:0] limit;
    logic enq_fire, deq_fire;

    always_comb begin
        int tail;
        int hnext;
        q_d      = q_q;
        limit    = q_q.lim_one ? CW'(1) : CW'(DEPTH);
        full     = (q_q.count == limit);
        empty    = (q_q.count == '0);
        enq_fire = enq_valid && !full;
        deq_fire = deq_ready && !empty;

        tail = int'(q_q.head) + int'(q_q.count);
        if (tail >= DEPTH) tail = tail - DEPTH;
        hnext = int'(q_q.head) + 1;
        if (hnext >= DEPTH) hnext = 0;

        if (enq_fire) begin
            q_d.kind[PW'(tail)] = enq_kind;
            q_d.addr[PW'(tail)] = enq_addr;
            q_d.line[PW'(tail)] = enq_line;
        end
        if (deq_fire) q_d.head = PW'(hnext);
        case ({enq_fire, deq_fire})
            2'b10:   q_d.count = q_q.count + CW'(1);
            2'b01:   q_d.count = q_q.count - CW'(1);
            default: q_d.count = q_q.count;
        endcase
        // depth limit is re-sampled only while nothing is held
        if (empty) q_d.lim_one = cfg_single;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign enq_ready = !full;
    assign deq_valid = !empty;
    assign deq_kind  = q_q.kind[q_q.head];
    assign deq_addr  = q_q.addr[q_q.head];
    assign deq_line  = q_q.line[q_q.head];
    assign slot_kind = q_q.kind;
    assign slot_addr = q_q.addr;
    assign slot_line = q_q.line;
    assign head      = q_q.head;
    assign count     = q_q.count;

    // R4: limit must not move while entries are held
    p_limit_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.count != '0) |=> (q_q.lim_one == $past(q_q.lim_one)));

    // R3: a full buffer never grows
    p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> (q_q.count <= $past(q_q.count)));

    // R2: stalled head entry is held steady
    p_head_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid && !deq_ready) |=> (deq_valid && $stable(deq_addr) && $stable(deq_kind)));

endmodule

// File: rtl/wbb_snoop.sv
module wbb_snoop
    import wbb_pkg::*;
#(
    parameter int AW    = 26,
    parameter int LW    = 512,
    parameter int BW    = 128,
    parameter int DEPTH = 2,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int BEATS = LW / BW,
    localparam int BIW   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       snp_req,
    input  logic [AW-1:0]              snp_addr,
    input  logic [DEPTH-1:0][1:0]      slot_kind,
    input  logic [DEPTH-1:0][AW-1:0]   slot_addr,
    input  logic [DEPTH-1:0][LW-1:0]   slot_line,
    input  logic [PW-1:0]              head,
    input  logic [CW-1:0]              count,
    output logic                       snp_busy,
    output logic                       snp_done,
    output logic                       snp_hit,
    output logic                       snp_beat_valid,
    output logic [BIW-1:0]             snp_beat_idx,
    output logic [BW-1:0]              snp_beat_data
);

    typedef struct packed {
        logic           active;
        logic [BIW-1:0] beat;
        logic           done;
        logic           hit;
        logic [LW-1:0]  line;
    } sstate_t;

    sstate_t s_q, s_d;
    logic          found;
    logic [PW-1:0] sel;

    // age-ordered scan: a later (newer) match overrides an older one
    always_comb begin
        int slot;
        found = 1'b0;
        sel   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            slot = int'(head) + k;
            if (slot >= DEPTH) slot = slot - DEPTH;
            if ((k < int'(count)) && kind_snoopable(slot_kind[PW'(slot)])
                && (slot_addr[PW'(slot)] == snp_addr)) begin
                found = 1'b1;
                sel   = PW'(slot);
            end
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.hit  = 1'b0;
        if (s_q.active) begin
            if (s_q.beat == BIW'(BEATS - 1)) s_d.active = 1'b0;
            else                             s_d.beat   = s_q.beat + BIW'(1);
        end else if (snp_req) begin
            s_d.done = 1'b1;
            s_d.hit  = found;
            if (found) begin
                s_d.active = 1'b1;
                s_d.beat   = '0;
                s_d.line   = slot_line[sel];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign snp_busy       = s_q.active;
    assign snp_done       = s_q.done;
    assign snp_hit        = s_q.hit;
    assign snp_beat_valid = s_q.active;
    assign snp_beat_idx   = s_q.beat;
    assign snp_beat_data  = s_q.line[s_q.beat*BW +: BW];

    // R7: beats advance by one each cycle until the last
    p_beat_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && s_q.beat != BIW'(BEATS - 1))
        |=> (s_q.active && s_q.beat == $past(s_q.beat) + BIW'(1)));

    // R5: requests during a stream are ignored
    p_busy_ignores_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.active |=> !s_q.done);

    // R5: a miss starts no stream
    p_miss_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.done && !s_q.hit) |-> !s_q.active);

    // R5: hit only reported in the result cycle
    p_hit_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        snp_hit |-> snp_done);

endmodule

// File: rtl/wb_line_buf.sv
module wb_line_buf #(
    parameter int AW        = 26,
    parameter int LINE_W    = 512,
    parameter int BEAT_W    = 128,
    parameter int MAX_DEPTH = 2,
    localparam int BEATS    = LINE_W / BEAT_W,
    localparam int BIW      = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int PW       = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1,
    localparam int CW       = $clog2(MAX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_single,
    input  logic              enq_valid,
    input  logic [1:0]        enq_kind,
    input  logic [AW-1:0]     enq_addr,
    input  logic [LINE_W-1:0] enq_line,
    output logic              enq_ready,
    input  logic              deq_ready,
    output logic              deq_valid,
    output logic [1:0]        deq_kind,
    output logic [AW-1:0]     deq_addr,
    output logic [LINE_W-1:0] deq_line,
    input  logic              snp_req,
    input  logic [AW-1:0]     snp_addr,
    output logic              snp_busy,
    output logic              snp_done,
    output logic              snp_hit,
    output logic              snp_beat_valid,
    output logic [BIW-1:0]    snp_beat_idx,
    output logic [BEAT_W-1:0] snp_beat_data,
    output logic              full,
    output logic              empty
);

    logic [MAX_DEPTH-1:0][1:0]        slot_kind;
    logic [MAX_DEPTH-1:0][AW-1:0]     slot_addr;
    logic [MAX_DEPTH-1:0][LINE_W-1:0] slot_line;
    logic [PW-1:0]                    head;
    logic [CW-1:0]                    count;

    wbb_queue #(.AW(AW), .LW(LINE_W), .DEPTH(MAX_DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .cfg_single(cfg_single),
        .enq_valid(enq_valid), .enq_kind(enq_kind), .enq_addr(enq_addr),
        .enq_line(enq_line), .enq_ready(enq_ready),
        .deq_ready(deq_ready), .deq_valid(deq_valid), .deq_kind(deq_kind),
        .deq_addr(deq_addr), .deq_line(deq_line),
        .full(full), .empty(empty),
        .slot_kind(slot_kind), .slot_addr(slot_addr), .slot_line(slot_line),
        .head(head), .count(count)
    );

    wbb_snoop #(.AW(AW), .LW(LINE_W), .BW(BEAT_W), .DEPTH(MAX_DEPTH)) u_snoop (
        .clk(clk), .rst_n(rst_n), .snp_req(snp_req), .snp_addr(snp_addr),
        .slot_kind(slot_kind), .slot_addr(slot_addr), .slot_line(slot_line),
        .head(head), .count(count),
        .snp_busy(snp_busy), .snp_done(snp_done), .snp_hit(snp_hit),
        .snp_beat_valid(snp_beat_valid), .snp_beat_idx(snp_beat_idx),
        .snp_beat_data(snp_beat_data)
    );

endmodule

// File: tb/wb_line_buf_test.sv
module wb_line_buf_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic         cfg_single = 1'b0;
    logic         enq_valid = 1'b0;
    logic [1:0]   enq_kind = 2'd0;
    logic [25:0]  enq_addr = '0;
    logic [511:0] enq_line = '0;
    logic         enq_ready;
    logic         deq_ready = 1'b0;
    logic         deq_valid;
    logic [1:0]   deq_kind;
    logic [25:0]  deq_addr;
    logic [511:0] deq_line;
    logic         snp_req = 1'b0;
    logic [25:0]  snp_addr = '0;
    logic         snp_busy, snp_done, snp_hit, snp_beat_valid;
    logic [1:0]   snp_beat_idx;
    logic [127:0] snp_beat_data;
    logic         full, empty;

    wb_line_buf uut (.*);

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string tag_q = "R3";
    string tag_s = "R5";

    // reference model
    logic [25:0]  m_addr[$];
    logic [1:0]   m_kind[$];
    logic [511:0] m_line[$];
    bit           m_lim1 = 0;
    bit           m_active = 0, m_done = 0, m_hit = 0;
    int           m_beat = 0;
    logic [511:0] m_sline = '0;

    task automatic chk(input string req, input string what,
                       input logic [511:0] got, input logic [511:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_addr.delete(); m_kind.delete(); m_line.delete();
            m_lim1 = 0; m_active = 0; m_done = 0; m_hit = 0; m_beat = 0;
        end else begin
            int lim;
            bit f;
            logic [511:0] fl;
            bit was_empty, efire, dfire;
            lim = m_lim1 ? 1 : 2;
            was_empty = (m_addr.size() == 0);
            efire = enq_valid && (m_addr.size() < lim);
            dfire = deq_ready && !was_empty;
            m_done = 0; m_hit = 0;
            if (m_active) begin
                if (m_beat == 3) m_active = 0; else m_beat++;
            end else if (snp_req) begin
                f = 0; fl = '0;
                for (int i = 0; i < m_addr.size(); i++)
                    if (m_kind[i] < 2 && m_addr[i] == snp_addr) begin f = 1; fl = m_line[i]; end
                m_done = 1; m_hit = f;
                if (f) begin m_active = 1; m_beat = 0; m_sline = fl; end
            end
            if (dfire) begin void'(m_addr.pop_front()); void'(m_kind.pop_front()); void'(m_line.pop_front()); end
            if (efire) begin m_addr.push_back(enq_addr); m_kind.push_back(enq_kind); m_line.push_back(enq_line); end
            if (was_empty) m_lim1 = cfg_single;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            int lim;
            bit e;
            lim = m_lim1 ? 1 : 2;
            e = (m_addr.size() == 0);
            chk(tag_q, "full", 512'(full), 512'(m_addr.size() == lim));
            chk(tag_q, "enq_ready", 512'(enq_ready), 512'(m_addr.size() < lim));
            chk("R2", "empty", 512'(empty), 512'(e));
            chk("R2", "deq_valid", 512'(deq_valid), 512'(!e));
            if (!e) begin
                chk("R2", "deq_addr", 512'(deq_addr), 512'(m_addr[0]));
                chk("R1", "deq_kind", 512'(deq_kind), 512'(m_kind[0]));
                chk("R1", "deq_line", deq_line, m_line[0]);
            end
            chk(tag_s, "snp_done", 512'(snp_done), 512'(m_done));
            chk(tag_s, "snp_hit", 512'(snp_hit), 512'(m_hit));
            chk("R7", "snp_busy", 512'(snp_busy), 512'(m_active));
            chk("R7", "snp_beat_valid", 512'(snp_beat_valid), 512'(m_active));
            if (m_active) begin
                chk("R7", "snp_beat_idx", 512'(snp_beat_idx), 512'(m_beat));
                chk("R7", "snp_beat_data", 512'(snp_beat_data), 512'(m_sline[m_beat*128 +: 128]));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog R2 actual=%0d expected=<100000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [511:0] mkline(input int seed);
        logic [511:0] l;
        for (int i = 0; i < 16; i++) l[i*32 +: 32] = 32'(seed * 32'h01010101 + i * 32'h1000 + 7);
        return l;
    endfunction

    task automatic step(); @(negedge clk); endtask
    task automatic idle(); enq_valid = 0; deq_ready = 0; snp_req = 0; endtask
    task automatic enq(input logic [1:0] k, input logic [25:0] a, input int s);
        enq_valid = 1; enq_kind = k; enq_addr = a; enq_line = mkline(s);
    endtask
    task automatic snoop(input logic [25:0] a); snp_req = 1; snp_addr = a; endtask
    task automatic wait_n(input int n); idle(); for (int i = 0; i < n; i++) step(); endtask
    task automatic drain(); idle(); deq_ready = 1; for (int i = 0; i < 3; i++) step(); deq_ready = 0; endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state while reset is held
        chk("R10", "empty", 512'(empty), 512'(1));
        chk("R10", "full", 512'(full), 512'(0));
        chk("R10", "deq_valid", 512'(deq_valid), 512'(0));
        chk("R10", "enq_ready", 512'(enq_ready), 512'(1));
        chk("R10", "snp_busy", 512'(snp_busy), 512'(0));
        chk("R10", "snp_done", 512'(snp_done), 512'(0));
        chk("R10", "snp_beat_valid", 512'(snp_beat_valid), 512'(0));
        rst_n = 1;
        step();

        // R1 R3: fill two, refused third
        enq(2'd0, 26'h100, 1); step();
        enq(2'd1, 26'h200, 2); step();
        enq(2'd2, 26'h300, 3); step();
        idle();
        // R5 R7: snoop each queued line
        snoop(26'h100); step(); wait_n(5);
        snoop(26'h200); step();
        snoop(26'h100); step();   // ignored while busy (R5)
        wait_n(5);
        snoop(26'h999); step(); wait_n(2);
        // R6: interrupt vector never hits
        deq_ready = 1; step(); idle();
        enq(2'd2, 26'h300, 4); step(); idle();
        tag_s = "R6";
        snoop(26'h300); step(); wait_n(2);
        snoop(26'h200); step(); wait_n(5);
        drain();
        enq(2'd3, 26'h300, 5); step(); idle();
        snoop(26'h300); step(); wait_n(2);
        drain();
        // R8: newest of two matches
        tag_s = "R8";
        enq(2'd0, 26'h444, 6); step();
        enq(2'd1, 26'h444, 7); step(); idle();
        snoop(26'h444); step(); wait_n(5);
        drain();
        // R9: same-edge dequeue still hits, same-edge enqueue misses
        tag_s = "R9";
        enq(2'd0, 26'h555, 8); step(); idle();
        snoop(26'h555); deq_ready = 1; step(); wait_n(5);
        snoop(26'h666); enq(2'd0, 26'h666, 9); step(); wait_n(2);
        drain();
        // R4: limit changes only when empty
        tag_q = "R4";
        enq(2'd0, 26'h10, 10); step(); idle();
        cfg_single = 1; step();
        enq(2'd0, 26'h11, 11); step(); idle(); step();
        drain(); wait_n(2);
        enq(2'd0, 26'h12, 12); step(); idle();
        enq(2'd0, 26'h13, 13); step(); idle();
        cfg_single = 0; step(); step();
        drain(); wait_n(2);
        enq(2'd0, 26'h14, 14); step();
        enq(2'd1, 26'h15, 15); step(); idle();
        drain();

        // random traffic
        tag_q = "R3"; tag_s = "R5";
        for (int n = 0; n < 3000; n++) begin
            enq_valid = ($urandom % 2) == 0;
            enq_kind  = 2'($urandom % 4);
            enq_addr  = 26'($urandom % 4);
            for (int w = 0; w < 16; w++) enq_line[w*32 +: 32] = $urandom;
            deq_ready = ($urandom % 3) == 0;
            snp_req   = ($urandom % 3) == 0;
            snp_addr  = 26'($urandom % 4);
            if (($urandom % 40) == 0) cfg_single = ~cfg_single;
            step();
        end
        idle(); step(); step();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule